// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt request lines from a set of devices and condenses them into one interrupt flag for a processor. Alongside the flag it presents the index of the winning device. One further input, reserved for serious faults, cannot be masked. When that input has fired, the block reports it with its own indication and a reserved identifier.

Each device request is latched into a pending bit. Software clears a pending bit by writing a one to it. A source is eligible when three things hold: its pending bit is set, its mask bit is clear, and the global enable is on. Software assigns every source a priority level through a small register port. Among the eligible sources, the one with the highest level wins. When levels are equal, the lower device index wins. A latched non-maskable request overrides all of this. The flag, the identifier and the non-maskable indication are registered outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the outputs are low and the identifier is 0. The control register (address 0) reads 0, the mask register (address 1) reads all ones, the pending register (address 2) reads 0, and every level register (address 4+i) reads 0.
- R2: A high request on line i sets pending bit i at the next clock. The bit stays set after the request drops. It clears only when software writes a one to bit i at address 2. If the request is still high during that write, the bit stays set.
- R3: `irq_o` is high exactly one clock after some source is eligible or the non-maskable latch is set. It is low one clock after neither holds. Eligible means pending, unmasked and globally enabled.
- R4: Mask bit i at 1 stops source i from raising or winning the interrupt. The source's pending bit still reads back at address 2.
- R5: Control bit 0 is the global enable. When it is 0, no maskable source raises the interrupt.
- R6: A high `nmi_i` sets a non-maskable latch. While that latch is set, the outputs show `irq_o`=1, `irq_nmi_o`=1 and identifier NUM_SRC, whatever the masks, the enable and the levels hold. The latch reads back at control bit 1. Writing a one to control bit 1 clears it.
- R7: Among eligible sources, the one with the numerically highest level (address 4+i, LVL_W bits) is reported.
- R8: Among eligible sources of equal level, the lowest index is reported.
- R9: Every register written through the port reads back its value. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Device request lines |
| nmi_i | input | 1 | Non-maskable request |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt flag to the processor |
| irq_id_o | output | ID_W | Winning device index, or NUM_SRC for the non-maskable source |
| irq_nmi_o | output | 1 | Non-maskable source is being reported |

## Verification
A corrupted pending bit appears in two places within two clocks of the fault. It shows as a stray or missing bit at address 2, and as a flag or identifier that does not match the masks and levels set by software. A selector fault shows as a wrong identifier one clock after the eligible set changes. This includes picking the wrong index on a tie and letting a low level beat a high one. A broken non-maskable path shows as a missing `irq_nmi_o`, or as a maskable identifier one clock after the latch is set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned A_CTRL      = 0;
  localparam int unsigned A_MASK      = 1;
  localparam int unsigned A_PEND      = 2;
  localparam int unsigned A_LVL_BASE  = 4;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_NMI_BIT = 1;

  // address of the level register for source idx
  function automatic int unsigned lvl_addr(input int unsigned idx);
    return A_LVL_BASE + idx;
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int unsigned N      = 8,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic [N-1:0]              pend_i,
  input  logic                      nmi_pend_i,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic [N-1:0]              mask_o,
  output logic                      gen_en_o,
  output logic [N-1:0][LVL_W-1:0]   lvl_o,
  output logic [N-1:0]              clr_o,
  output logic                      nmi_clr_o
);
  import irqc_pkg::*;

  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_MASK);
  localparam logic [ADDR_W-1:0] AD_PEND = ADDR_W'(A_PEND);

  logic wr_hit;
  assign wr_hit = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o   <= '1;
      gen_en_o <= 1'b0;
    end else if (wr_hit) begin
      if (bus_addr == AD_CTRL) gen_en_o <= bus_wdata[CTRL_EN_BIT];
      if (bus_addr == AD_MASK) mask_o   <= bus_wdata[N-1:0];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lvl
    localparam logic [ADDR_W-1:0] AD_LVL = ADDR_W'(lvl_addr(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             lvl_o[g] <= '0;
      else if (wr_hit && bus_addr == AD_LVL)  lvl_o[g] <= bus_wdata[LVL_W-1:0];
    end
  end

  assign clr_o     = (wr_hit && bus_addr == AD_PEND) ? bus_wdata[N-1:0] : '0;
  assign nmi_clr_o = wr_hit && (bus_addr == AD_CTRL) && bus_wdata[CTRL_NMI_BIT];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AD_CTRL) begin
      bus_rdata[CTRL_EN_BIT]  = gen_en_o;
      bus_rdata[CTRL_NMI_BIT] = nmi_pend_i;
    end
    if (bus_addr == AD_MASK) bus_rdata[N-1:0] = mask_o;
    if (bus_addr == AD_PEND) bus_rdata[N-1:0] = pend_i;
    for (int i = 0; i < N; i++) begin
      if (bus_addr == ADDR_W'(lvl_addr(i))) bus_rdata[LVL_W-1:0] = lvl_o[i];
    end
  end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         nmi_i,
  input  logic [N-1:0] clr_i,
  input  logic         nmi_clr_i,
  output logic [N-1:0] pend_o,
  output logic         nmi_pend_o
);
  // a live request wins over a same-cycle clear
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[g] <= 1'b0;
      else        pend_o[g] <= (pend_o[g] & ~clr_i[g]) | req_i[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_pend_o <= 1'b0;
    else        nmi_pend_o <= (nmi_pend_o & ~nmi_clr_i) | nmi_i;
  end
endmodule

// File: rtl/irqc_sel.sv
module irqc_sel #(
  parameter int unsigned N     = 8,
  parameter int unsigned LVL_W = 3,
  parameter int unsigned ID_W  = 4
) (
  input  logic [N-1:0]              elig_i,
  input  logic [N-1:0][LVL_W-1:0]   lvl_i,
  output logic                      win_valid_o,
  output logic [ID_W-1:0]           win_id_o
);
  // strict compare: an equal level never displaces an earlier (lower) index
  function automatic logic beats(input logic found, input logic [LVL_W-1:0] cand,
                                 input logic [LVL_W-1:0] best);
    return !found || (cand > best);
  endfunction

  logic [LVL_W-1:0] best_lvl;

  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    best_lvl    = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && beats(win_valid_o, lvl_i[i], best_lvl)) begin
        win_valid_o = 1'b1;
        win_id_o    = ID_W'(i);
        best_lvl    = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               nmi_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic               irq_nmi_o
);
  localparam logic [ID_W-1:0] NMI_ID = ID_W'(NUM_SRC);

  logic [NUM_SRC-1:0]             mask, pend, clr_vec, elig;
  logic [NUM_SRC-1:0][LVL_W-1:0]  lvl;
  logic                           gen_en, nmi_pend, nmi_clr;
  logic                           win_valid;
  logic [ID_W-1:0]                win_id;

  irqc_regs #(.N(NUM_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_i(pend), .nmi_pend_i(nmi_pend),
    .bus_rdata(bus_rdata), .mask_o(mask), .gen_en_o(gen_en), .lvl_o(lvl),
    .clr_o(clr_vec), .nmi_clr_o(nmi_clr)
  );

  irqc_pend #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .nmi_i(nmi_i), .clr_i(clr_vec),
    .nmi_clr_i(nmi_clr), .pend_o(pend), .nmi_pend_o(nmi_pend)
  );

  assign elig = pend & ~mask & {NUM_SRC{gen_en}};

  irqc_sel #(.N(NUM_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_sel (
    .elig_i(elig), .lvl_i(lvl), .win_valid_o(win_valid), .win_id_o(win_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      irq_nmi_o <= 1'b0;
      irq_id_o  <= '0;
    end else if (nmi_pend) begin
      irq_o     <= 1'b1;
      irq_nmi_o <= 1'b1;
      irq_id_o  <= NMI_ID;
    end else begin
      irq_o     <= win_valid;
      irq_nmi_o <= 1'b0;
      irq_id_o  <= win_valid ? win_id : '0;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned N    = 8,
  parameter int unsigned ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_i,
  input logic [N-1:0]    pend,
  input logic [N-1:0]    clr_vec,
  input logic [N-1:0]    elig,
  input logic            nmi_pend,
  input logic            irq_o,
  input logic            irq_nmi_o,
  input logic [ID_W-1:0] irq_id_o
);
  assert_flag_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|elig) || nmi_pend) |=> irq_o);

  assert_flag_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|elig) && !nmi_pend) |=> !irq_o);

  assert_nmi_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |=> (irq_nmi_o && irq_id_o == ID_W'(N)));

  assert_nmi_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nmi_o |-> irq_o);

  assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_nmi_o) |-> (irq_id_o < ID_W'(N)) && ((($past(elig) >> irq_id_o) & 1) != 0));

  for (genvar g = 0; g < N; g++) begin : g_bit
    assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[g] |=> pend[g]);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !clr_vec[g]) |=> pend[g]);
  end
endmodule

bind prio_irq_ctrl irqc_chk #(.N(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .pend(pend), .clr_vec(clr_vec),
  .elig(elig), .nmi_pend(nmi_pend), .irq_o(irq_o), .irq_nmi_o(irq_nmi_o),
  .irq_id_o(irq_id_o)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          nmi = 1'b0;
  logic          sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq, irq_nmi;
  logic [IW-1:0] irq_id;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .LVL_W(LW), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .nmi_i(nmi), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_o(irq), .irq_id_o(irq_id), .irq_nmi_o(irq_nmi)
  );

  typedef struct {
    logic          flag;
    logic          nm;
    logic [IW-1:0] id;
    string         tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int total = 0;
  int bad   = 0;

  task automatic note(input bit ok, input string tag, input string what,
                      input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: compares the oldest expected item against the outputs
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      cur = sb.pop_front();
      note(irq == cur.flag, cur.tag, "irq_o", int'(irq), int'(cur.flag));
      note(irq_nmi == cur.nm, cur.tag, "irq_nmi_o", int'(irq_nmi), int'(cur.nm));
      note(irq_id == cur.id, cur.tag, "irq_id_o", int'(irq_id), int'(cur.id));
    end
  end

  // driver side: wait for pending and output registers, then post expectation
  task automatic expect_out(input logic f, input logic n, input int id, input string tag);
    exp_t e;
    repeat (2) @(posedge clk);
    e.flag = f; e.nm = n; e.id = IW'(id); e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic wr_reg(input int a, input int d);
    sel = 1'b1; wr = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(posedge clk);
    #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    addr = AW'(a);
    #1;
    note(rdata == DW'(exp), tag, $sformatf("read@%0d", a), int'(rdata), exp);
  endtask

  task automatic pulse_req(input int idx);
    req[idx] = 1'b1;
    @(posedge clk);
    #1;
    req[idx] = 1'b0;
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_out(1'b0, 1'b0, 0, "R1");
    rd_chk(0, 0, "R1");
    rd_chk(1, 8'hFF, "R1");
    rd_chk(2, 0, "R1");
    rd_chk(4, 0, "R1");
    rd_chk(11, 0, "R1");
    // R4: masked (reset masks) and disabled, request only pends
    pulse_req(6);
    expect_out(1'b0, 1'b0, 0, "R4");
    rd_chk(2, 8'h40, "R4");
    wr_reg(2, 8'h40);
    // enable everything
    wr_reg(0, 1);
    wr_reg(1, 0);
    rd_chk(0, 1, "R9");
    rd_chk(1, 0, "R9");
    // R2/R3 single pulse latched
    pulse_req(3);
    expect_out(1'b1, 1'b0, 3, "R3");
    rd_chk(2, 8'h08, "R2");
    // R7 higher level wins
    wr_reg(4 + 5, 4);
    rd_chk(9, 4, "R9");
    pulse_req(5);
    expect_out(1'b1, 1'b0, 5, "R7");
    wr_reg(2, 8'h20);
    expect_out(1'b1, 1'b0, 3, "R2");
    // R8 tie goes to lower index
    pulse_req(1);
    expect_out(1'b1, 1'b0, 1, "R8");
    wr_reg(4 + 3, 2);
    expect_out(1'b1, 1'b0, 3, "R7");
    // R4 mask source 3
    wr_reg(1, 8'h08);
    expect_out(1'b1, 1'b0, 1, "R4");
    rd_chk(2, 8'h0A, "R4");
    // R5 global disable
    wr_reg(0, 0);
    expect_out(1'b0, 1'b0, 0, "R5");
    // R6 non-maskable bypasses disable
    nmi = 1'b1; @(posedge clk); #1 nmi = 1'b0;
    expect_out(1'b1, 1'b1, N, "R6");
    rd_chk(0, 2, "R6");
    wr_reg(0, 1);
    wr_reg(1, 0);
    wr_reg(4 + 1, 7);
    expect_out(1'b1, 1'b1, N, "R6");
    wr_reg(0, 3);
    expect_out(1'b1, 1'b0, 1, "R6");
    rd_chk(0, 1, "R6");
    // R2 clear while request held keeps bit
    req[0] = 1'b1;
    wr_reg(2, 1);
    rd_chk(2, 8'h0B, "R2");
    req[0] = 1'b0;
    @(posedge clk); #1;
    wr_reg(2, 1);
    rd_chk(2, 8'h0A, "R2");
    // R3 all cleared drops flag
    wr_reg(2, 8'hFF);
    expect_out(1'b0, 1'b0, 0, "R3");
    rd_chk(2, 0, "R2");
    rd_chk(3, 0, "R9");
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule